// File: doc/BRIEF.md
# Truncating Brain-Float Multiplier

This block multiplies two 16-bit brain-float operands and returns their product in the same format. A word holds a sign in bit 15 (1 = negative), a biased exponent in bits 14:7 (bias 127) and a 7-bit fraction in bits 6:0. Every word whose exponent field is nonzero stands for a normalized value with a hidden leading 1. A word whose exponent field is 0 stands for zero. The format has no infinities and no not-a-number codes. Results are always truncated, never rounded.

The datapath takes three steps. It unpacks both operands. It multiplies the two 8-bit significands and keeps only the upper bits. It then normalizes the product and forms the exponent, which is forced to zero on underflow and clamped on overflow. A parameter selects whether the result leaves through a register or straight from the logic. With the default setting the product appears one clock after its operands. Field widths are parameters; the defaults give the 16-bit format.

Top module: `bf16_mul`

## Requirements
- R1: For every nonzero result, bit 15 of the product equals the XOR of bit 15 of the two operands.
- R2: An operand whose exponent field (bits 14:7) is 0 is zero whatever its fraction bits hold, and the product is then 16'h0000.
- R3: When the significand product is below 2, the result exponent field is ea + eb - 127. The result fraction is then bits 13:7 of the 16-bit product of the two significands {1,fraction}.
- R4: When bit 15 of the significand product is set, the result exponent is one higher than in R3 and the result fraction is bits 14:8 of that product.
- R5: The bits of the product below the kept fraction are discarded without rounding. For example, 16'h3F81 times 16'h3F81 gives 16'h3F82, and 16'h3FFF times 16'h3FFF gives 16'h407E.
- R6: If the final exponent would be below 1, the product is 16'h0000 (positive zero) whatever the operand signs.
- R7: If the final exponent would exceed 254, the product is the largest finite value of the correct sign: exponent field 8'hFE and fraction 7'h7F.
- R8: With the output register selected (the default), the product of the operands present at a rising clock edge appears at p after that edge. While rst_n is low, p is 16'h0000.
- R9: The exponent values 1 and 254 are passed through unchanged, including the case where the R4 increment lifts a sum of 0 up to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the output register |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| p | output | 16 | Product, registered by default |

## Verification
The normalization increment and the exponent limits can act in the same cycle. A significand product of 2 or more can push a sum of 254 over the top into saturation, and it can rescue a sum of 0 up to exponent 1 instead of flushing it to zero. The bench provokes both cases with full-fraction operands whose biased exponents add to exactly 381 or exactly 127. Each result is judged against a reference model built on real numbers. That model finds the exponent by repeated halving and truncates the fraction, so it shares no arithmetic with the hardware path.

// File: rtl/bf16_mul_pkg.sv
package bf16_mul_pkg;

   localparam int unsigned DEF_EXP_W = 8;
   localparam int unsigned DEF_MAN_W = 7;

   typedef enum logic [1:0] {
      RES_NORMAL   = 2'd0,
      RES_ZERO     = 2'd1,
      RES_SATURATE = 2'd2
   } res_kind_e;

   function automatic int bias_of(input int exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/bf16_unpack.sv
module bf16_unpack #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 7,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0]     op,
   output logic             sign,
   output logic [EXP_W-1:0] expo,
   output logic [MAN_W:0]   sig,
   output logic             is_zero
);

   assign sign    = op[W-1];
   assign expo    = op[W-2 -: EXP_W];
   assign is_zero = (expo == '0);
   assign sig     = {1'b1, op[MAN_W-1:0]};

endmodule

// File: rtl/bf16_sig_mul.sv
module bf16_sig_mul #(
   parameter int unsigned MAN_W = 7,
   localparam int unsigned SW = MAN_W + 1,
   localparam int unsigned PW = 2 * SW,
   localparam int unsigned HW = PW - MAN_W
) (
   input  logic [SW-1:0]    sig_a,
   input  logic [SW-1:0]    sig_b,
   output logic [MAN_W-1:0] man,
   output logic             carry
);

   logic [PW-1:0] a_x, b_x;
   logic [HW-1:0] hi;

   assign a_x = PW'(sig_a);
   assign b_x = PW'(sig_b);
   assign hi  = HW'((a_x * b_x) >> MAN_W);

   assign carry = hi[HW-1];
   assign man   = carry ? hi[HW-2:1] : hi[HW-3:0];

   // a product of two significands in [1,2) lies in [1,4)
   always_comb begin
      assert_sig_range_R4 : assert (hi[HW-1] | hi[HW-2])
         else $error("significand product below one");
   end

endmodule

// File: rtl/bf16_exp_pack.sv
module bf16_exp_pack
   import bf16_mul_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 7,
   localparam int unsigned W  = 1 + EXP_W + MAN_W,
   localparam int unsigned XW = EXP_W + 2
) (
   input  logic             sign,
   input  logic [EXP_W-1:0] exp_a,
   input  logic [EXP_W-1:0] exp_b,
   input  logic             any_zero,
   input  logic             carry,
   input  logic [MAN_W-1:0] man,
   output logic [W-1:0]     res
);

   localparam logic signed [XW-1:0] BIAS = XW'(bias_of(EXP_W));
   localparam logic signed [XW-1:0] EMAX = XW'((1 << EXP_W) - 2);
   localparam logic signed [XW-1:0] EMIN = XW'(1);

   logic signed [XW-1:0] e_sum;
   res_kind_e            kind;

   assign e_sum = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b})
                - BIAS + $signed(XW'(carry));

   always_comb begin
      if (any_zero || (e_sum < EMIN)) kind = RES_ZERO;
      else if (e_sum > EMAX)           kind = RES_SATURATE;
      else                             kind = RES_NORMAL;
   end

   always_comb begin
      unique case (kind)
         RES_ZERO:     res = '0;
         RES_SATURATE: res = {sign, EMAX[EXP_W-1:0], {MAN_W{1'b1}}};
         default:      res = {sign, e_sum[EXP_W-1:0], man};
      endcase
   end

   // the all-ones exponent is never produced
   always_comb begin
      assert_no_top_exp_R7 : assert (res[W-2 -: EXP_W] != {EXP_W{1'b1}})
         else $error("reserved exponent produced");
   end

endmodule

// File: rtl/bf16_mul.sv
module bf16_mul
   import bf16_mul_pkg::*;
#(
   parameter int unsigned EXP_W   = DEF_EXP_W,
   parameter int unsigned MAN_W   = DEF_MAN_W,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] p
);

   initial begin
      assert_param_exp_R3 : assert (EXP_W >= 3 && EXP_W <= 16)
         else $error("EXP_W out of range");
      assert_param_man_R3 : assert (MAN_W >= 2 && MAN_W <= 24)
         else $error("MAN_W out of range");
   end

   logic [W-1:0]     ops   [2];
   logic             signs [2];
   logic [EXP_W-1:0] exps  [2];
   logic [MAN_W:0]   sigs  [2];
   logic             zeros [2];

   assign ops[0] = a;
   assign ops[1] = b;

   for (genvar i = 0; i < 2; i++) begin : g_unpack
      bf16_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_unpack (
         .op(ops[i]), .sign(signs[i]), .expo(exps[i]),
         .sig(sigs[i]), .is_zero(zeros[i])
      );
   end

   logic [MAN_W-1:0] man;
   logic             carry;
   logic [W-1:0]     res;

   bf16_sig_mul #(.MAN_W(MAN_W)) i_sig_mul (
      .sig_a(sigs[0]), .sig_b(sigs[1]), .man(man), .carry(carry)
   );

   bf16_exp_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_exp_pack (
      .sign(signs[0] ^ signs[1]), .exp_a(exps[0]), .exp_b(exps[1]),
      .any_zero(zeros[0] | zeros[1]), .carry(carry), .man(man), .res(res)
   );

   if (OUT_REG) begin : g_reg
      logic [W-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q <= '0;
         else        p_q <= res;
      end
      assign p = p_q;

      assert_sign_xor_R1 : assert property (@(posedge clk) disable iff (!rst_n)
         (p != '0) |-> (p[W-1] == ($past(a[W-1]) ^ $past(b[W-1]))))
         else $error("product sign wrong");

      assert_zero_in_R2 : assert property (@(posedge clk) disable iff (!rst_n)
         (($past(a[W-2 -: EXP_W]) == '0) || ($past(b[W-2 -: EXP_W]) == '0))
         |-> (p == '0))
         else $error("zero operand gave nonzero product");

      assert_pos_zero_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (p[W-2 -: EXP_W] == '0) |-> (p == '0))
         else $error("zero exponent with sign or fraction");
   end else begin : g_comb
      assign p = res;
   end

endmodule

// File: tb/test_bf16_mul.sv
`timescale 1ns/1ps
module test_bf16_mul;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a = '0;
   logic [15:0] b = '0;
   logic [15:0] p;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [15:0] exp_q [$];
   logic [15:0] a_q   [$];
   logic [15:0] b_q   [$];
   string       tag_q [$];

   always #4 clk = ~clk;

   bf16_mul i_bf16_mul (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p));

   function automatic logic [15:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
      int  ex, ey, e, be, frac;
      real m;
      logic s;
      ex = int'(x[14:7]);
      ey = int'(y[14:7]);
      if (ex == 0 || ey == 0) return 16'h0000;
      m = (1.0 + real'(x[6:0]) / 128.0) * (1.0 + real'(y[6:0]) / 128.0);
      e = (ex - 127) + (ey - 127);
      while (m >= 2.0) begin
         m = m / 2.0;
         e = e + 1;
      end
      be = e + 127;
      s  = x[15] ^ y[15];
      if (be < 1)   return 16'h0000;
      if (be > 254) return {s, 8'hFE, 7'h7F};
      frac = $rtoi((m - 1.0) * 128.0);
      return {s, be[7:0], frac[6:0]};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic drive(input logic [15:0] x, input logic [15:0] y, input string tag);
      @(negedge clk);
      a = x;
      b = y;
      exp_q.push_back(ref_mul(x, y));
      a_q.push_back(x);
      b_q.push_back(y);
      tag_q.push_back(tag);
   endtask

   // monitor: result of operands set at a negedge is visible after the next posedge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [15:0] e, xa, xb;
            string t;
            e  = exp_q.pop_front();
            xa = a_q.pop_front();
            xb = b_q.pop_front();
            t  = tag_q.pop_front();
            check($sformatf("%s a=%h b=%h", t, xa, xb), p, e);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      a = 16'h3FC0;
      b = 16'h3FC0;
      repeat (3) @(negedge clk);
      check("R8 reset clears output", p, 16'h0000);
      rst_n = 1'b1;

      drive(16'h3F80, 16'h3F80, "R3 one times one");
      drive(16'h4040, 16'h3FA0, "R3 no carry");
      drive(16'h3FC0, 16'h3FC0, "R4 carry path");
      drive(16'hC000, 16'h4040, "R1 negative times positive");
      drive(16'hC0A0, 16'hBFE0, "R1 negative times negative");
      drive(16'h0000, 16'h4040, "R2 zero operand");
      drive(16'h007F, 16'h3F80, "R2 zero exponent with fraction");
      drive(16'h8000, 16'hC000, "R2 negative zero gives plus zero");
      drive(16'h3F81, 16'h3F81, "R5 truncation low");
      drive(16'h3FFF, 16'h3FFF, "R5 truncation high");
      drive(16'h0080, 16'h0080, "R6 underflow");
      drive(16'h8080, 16'h0080, "R6 underflow negative");
      drive(16'h7F00, 16'h4000, "R7 overflow");
      drive(16'hFF00, 16'h4000, "R7 overflow negative");
      drive(16'h7F7F, 16'h3FFF, "R7 carry pushes into saturation");
      drive(16'h7FFF, 16'hFFFF, "R7 largest exponents");
      drive(16'h2000, 16'h2000, "R9 exponent one");
      drive(16'h7F00, 16'h3F80, "R9 exponent 254");
      drive(16'h1FFF, 16'h207F, "R9 carry rescues sum zero");
      drive(16'h3F80, 16'h3F80, "R8 back to back");

      lfsr = 32'hACE1_2468;
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] ra, rb;
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         ra = lfsr[15:0];
         rb = lfsr[31:16];
         drive(ra, rb, "R1 R3 R4 random");
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule